// File: doc/BRIEF.md
# Reorder-Class Instruction Steering Unit

This unit sits directly after instruction decode in an out-of-order core whose issue stage is split in two: a set of in-order FIFO lanes for code the compiler has already scheduled well, and a small associative queue for code that still needs dynamic reordering. The compiler puts one marker instruction in front of every basic block. The marker carries two bits: a reorder class (low or high) and a miss-heavy flag. The unit takes in each marker and keeps it. It updates its per-block routing state and then sends every following ordinary instruction to the destination chosen for that block. The choice holds until the next marker arrives.

A high-reorder block with the miss-heavy flag set starts a redirect window. A saturating counter is loaded with a programmable limit, clamped to a design-time cap. Each later marker takes one step off the window. While the window is open, the block that marker starts goes to the associative queue, even if its tag says low reorder. The unit holds no buffers of its own. An ordinary instruction is accepted in the same cycle in which its chosen destination can take it. Otherwise the decode stream stalls in place, so the order of instructions never changes. A synchronous flush returns the routing state and the counter to their reset values.

Top module: `rsq_steer`

## Requirements
- R1: After reset the counter is zero and the current route is the associative queue. An ordinary instruction presented before any marker appears on the associative output.
- R2: A marker (`in_is_marker`=1) is always accepted when no flush is active (`in_ready`=1). It never appears on either output.
- R3: A low-reorder marker (`in_tag_high`=0) that arrives with the counter at zero routes every following ordinary instruction to the FIFO output, up to the next marker.
- R4: A high-reorder marker (`in_tag_high`=1) routes its block to the associative output.
- R5: A high-reorder marker with `in_tag_miss`=1 loads the counter with the limit. This happens even when a window is already open. The limit is `cfg_redirect_max` clamped to `REDIRECT_CAP`. The next that-many markers then route their blocks to the associative output whatever their tag.
- R6: Every accepted marker that is not high-reorder with the miss flag set decrements a non-zero counter by one. This includes a high-reorder marker without the flag. A counter at zero stays at zero.
- R7: The miss flag on a low-reorder marker has no effect. It opens no window.
- R8: For an ordinary instruction, `in_ready` equals the ready input of the current destination. The ready input of the other destination has no effect. A stalled instruction stays where it is and is not reordered.
- R9: While `flush` is high, nothing is accepted and neither output is valid. After a flush the counter is zero and the route is the associative queue.
- R10: With a limit of zero, a miss-heavy high-reorder marker opens no window. The next low-reorder marker routes its block to the FIFO output.
- R11: A `cfg_redirect_max` above `REDIRECT_CAP` (default 3) opens a window of exactly `REDIRECT_CAP` blocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Synchronous pipeline flush |
| cfg_redirect_max | input | CFG_W (3) | Programmed redirect window length |
| in_valid | input | 1 | Decode slot holds an instruction |
| in_is_marker | input | 1 | Slot holds a block marker |
| in_tag_high | input | 1 | Marker reorder class: 1 = high, 0 = low |
| in_tag_miss | input | 1 | Marker miss-heavy flag |
| in_payload | input | W (8) | Decoded instruction payload |
| in_ready | output | 1 | Slot is accepted this cycle |
| fifo_valid | output | 1 | Instruction offered to FIFO lanes |
| fifo_payload | output | W (8) | Payload to FIFO lanes |
| fifo_ready | input | 1 | FIFO lanes can accept |
| assoc_valid | output | 1 | Instruction offered to associative queue |
| assoc_payload | output | W (8) | Payload to associative queue |
| assoc_ready | input | 1 | Associative queue can accept |

## Verification
The main routing function is exercised with several kinds of marker sequence. Plain low and high markers show that routing follows the tag. Miss-heavy markers followed by a run of low markers show that the window length is counted in blocks. A high marker without the flag placed inside a window shows that every marker, not only low ones, shortens the window. A second miss-heavy marker inside an open window shows that it reloads rather than adds. Limit values of zero, in range and above the cap separate the clamp from an off-by-one in the count. Readiness patterns with only the other destination ready show that backpressure follows the current route.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

  typedef enum logic {
    DEST_FIFO  = 1'b0,
    DEST_ASSOC = 1'b1
  } dest_e;

  // Window length actually loaded: programmed value limited to the cap.
  function automatic int clamp_limit(input int programmed, input int cap);
    return (programmed > cap) ? cap : programmed;
  endfunction

  // Counter value after an accepted marker.
  function automatic int step_count(input int cur, input int lim, input bit reload);
    if (reload)       return lim;
    else if (cur > 0) return cur - 1;
    else              return 0;
  endfunction

  // Destination of the block a marker opens.
  function automatic dest_e block_dest(input bit tag_high, input bit window_open);
    return (tag_high || window_open) ? DEST_ASSOC : DEST_FIFO;
  endfunction

endpackage

// File: rtl/rsq_marker_decode.sv
module rsq_marker_decode (
  input  logic in_valid,
  input  logic in_is_marker,
  input  logic in_tag_high,
  input  logic in_tag_miss,
  input  logic flush,
  output logic mark_take,
  output logic mark_high,
  output logic mark_reload,
  output logic instr_slot
);
  // A marker is consumed here whenever no flush is pending.
  assign mark_take   = in_valid && in_is_marker && !flush;
  assign mark_high   = in_tag_high;
  // Miss flag counts only with a high-reorder tag (R7).
  assign mark_reload = mark_take && in_tag_high && in_tag_miss;
  assign instr_slot  = in_valid && !in_is_marker && !flush;
endmodule

// File: rtl/rsq_redirect_ctr.sv
module rsq_redirect_ctr #(
  parameter int CFG_W        = 3,
  parameter int REDIRECT_CAP = 3,
  parameter int CW           = $clog2(REDIRECT_CAP + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             mark_take,
  input  logic             mark_reload,
  input  logic [CFG_W-1:0] cfg_max,
  output logic [CW-1:0]    cnt,
  output logic             window_open
);
  logic [CW-1:0] lim;
  logic [CW-1:0] cnt_nxt;

  assign lim         = CW'(rsq_pkg::clamp_limit(int'(cfg_max), REDIRECT_CAP));
  assign cnt_nxt     = CW'(rsq_pkg::step_count(int'(cnt), int'(lim), mark_reload));
  assign window_open = (cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (flush)     cnt <= '0;
    else if (mark_take) cnt <= cnt_nxt;
  end

  p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mark_reload |=> cnt == (($past(cfg_max) > REDIRECT_CAP) ? CW'(REDIRECT_CAP) : CW'($past(cfg_max))));

  p_decrement_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mark_take && !mark_reload && cnt != '0) |=> cnt == $past(cnt) - 1'b1);

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!mark_take && !flush) |=> $stable(cnt));

  p_flush_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> cnt == '0);

  p_cap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt) <= REDIRECT_CAP);
endmodule

// File: rtl/rsq_route_reg.sv
module rsq_route_reg (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           flush,
  input  logic           mark_take,
  input  logic           mark_high,
  input  logic           window_open,
  output rsq_pkg::dest_e route
);
  import rsq_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         route <= DEST_ASSOC;
    else if (flush)     route <= DEST_ASSOC;
    else if (mark_take) route <= block_dest(mark_high, window_open);
  end

  p_high_to_assoc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mark_take && mark_high) |=> route == DEST_ASSOC);

  p_window_to_assoc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mark_take && window_open) |=> route == DEST_ASSOC);

  p_low_to_fifo_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mark_take && !mark_high && !window_open) |=> route == DEST_FIFO);

  p_flush_route_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> route == DEST_ASSOC);
endmodule

// File: rtl/rsq_steer.sv
module rsq_steer #(
  parameter int W            = 8,
  parameter int CFG_W        = 3,
  parameter int REDIRECT_CAP = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [CFG_W-1:0] cfg_redirect_max,
  input  logic             in_valid,
  input  logic             in_is_marker,
  input  logic             in_tag_high,
  input  logic             in_tag_miss,
  input  logic [W-1:0]     in_payload,
  output logic             in_ready,
  output logic             fifo_valid,
  output logic [W-1:0]     fifo_payload,
  input  logic             fifo_ready,
  output logic             assoc_valid,
  output logic [W-1:0]     assoc_payload,
  input  logic             assoc_ready
);
  import rsq_pkg::*;
  localparam int CW = $clog2(REDIRECT_CAP + 1);

  logic           mark_take, mark_high, mark_reload, instr_slot;
  logic [CW-1:0]  cnt;
  logic           window_open;
  dest_e          route;
  logic           dest_ready;

  rsq_marker_decode u_dec (
    .in_valid    (in_valid),
    .in_is_marker(in_is_marker),
    .in_tag_high (in_tag_high),
    .in_tag_miss (in_tag_miss),
    .flush       (flush),
    .mark_take   (mark_take),
    .mark_high   (mark_high),
    .mark_reload (mark_reload),
    .instr_slot  (instr_slot)
  );

  rsq_redirect_ctr #(.CFG_W(CFG_W), .REDIRECT_CAP(REDIRECT_CAP), .CW(CW)) u_ctr (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .mark_take  (mark_take),
    .mark_reload(mark_reload),
    .cfg_max    (cfg_redirect_max),
    .cnt        (cnt),
    .window_open(window_open)
  );

  rsq_route_reg u_route (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .mark_take  (mark_take),
    .mark_high  (mark_high),
    .window_open(window_open),
    .route      (route)
  );

  assign dest_ready = (route == DEST_FIFO) ? fifo_ready : assoc_ready;

  always_comb begin
    if (flush)             in_ready = 1'b0;
    else if (in_is_marker) in_ready = 1'b1;
    else                   in_ready = dest_ready;
  end

  assign fifo_valid    = instr_slot && (route == DEST_FIFO);
  assign assoc_valid   = instr_slot && (route == DEST_ASSOC);
  assign fifo_payload  = in_payload;
  assign assoc_payload = in_payload;

  p_marker_dropped_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_is_marker) |-> (!fifo_valid && !assoc_valid));

  p_single_dest_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fifo_valid, assoc_valid}));

  p_stall_fifo_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_valid && !fifo_ready) |-> !in_ready);

  p_stall_assoc_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (assoc_valid && !assoc_ready) |-> !in_ready);

  p_flush_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (!in_ready && !fifo_valid && !assoc_valid));
endmodule

// File: tb/sim_rsq_steer.sv
module sim_rsq_steer;
  localparam int W = 8;
  localparam int NV = 36;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush = 1'b0;
  logic [2:0] cfg = 3'd2;
  logic in_valid = 1'b0, in_is_marker = 1'b0, in_tag_high = 1'b0, in_tag_miss = 1'b0;
  logic [W-1:0] in_payload = '0;
  logic fifo_ready = 1'b1, assoc_ready = 1'b1;
  logic in_ready, fifo_valid, assoc_valid;
  logic [W-1:0] fifo_payload, assoc_payload;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rsq_steer u0 (
    .clk(clk), .rst_n(rst_n), .flush(flush), .cfg_redirect_max(cfg),
    .in_valid(in_valid), .in_is_marker(in_is_marker), .in_tag_high(in_tag_high),
    .in_tag_miss(in_tag_miss), .in_payload(in_payload), .in_ready(in_ready),
    .fifo_valid(fifo_valid), .fifo_payload(fifo_payload), .fifo_ready(fifo_ready),
    .assoc_valid(assoc_valid), .assoc_payload(assoc_payload), .assoc_ready(assoc_ready)
  );

  // Vector: {req[3:0], marker, high, miss, cfg[2:0], fifo_rdy, assoc_rdy, exp_fifo_v, exp_assoc_v, exp_ready, 0}
  function automatic logic [15:0] mkv(int req, bit mk, bit hi, bit ms, int c,
                                      bit fr, bit ar, bit ef, bit ea, bit er);
    return {4'(req), mk, hi, ms, 3'(c), fr, ar, ef, ea, er, 1'b0};
  endfunction

  localparam logic [15:0] VEC [NV] = '{
    mkv(1, 0,0,0,2, 1,1, 0,1,1),  // R1 instr before any marker -> assoc
    mkv(3, 1,0,0,2, 1,1, 0,0,1),  // R3 low marker
    mkv(3, 0,0,0,2, 1,1, 1,0,1),  // R3 instr -> fifo
    mkv(8, 0,0,0,2, 0,1, 1,0,0),  // R8 fifo not ready: stall
    mkv(8, 0,0,0,2, 1,0, 1,0,1),  // R8 assoc ready ignored
    mkv(4, 1,1,0,2, 1,1, 0,0,1),  // R4 high marker
    mkv(4, 0,0,0,2, 1,1, 0,1,1),  // R4 instr -> assoc
    mkv(8, 0,0,0,2, 1,0, 0,1,0),  // R8 assoc not ready: stall
    mkv(5, 1,1,1,2, 1,1, 0,0,1),  // R5 high+miss, window 2
    mkv(5, 0,0,0,2, 1,1, 0,1,1),
    mkv(5, 1,0,0,2, 0,0, 0,0,1),  // R5 low marker redirected, R2 ready w/o dest
    mkv(5, 0,0,0,2, 1,1, 0,1,1),
    mkv(6, 1,1,0,2, 1,1, 0,0,1),  // R6 high no-miss uses last step
    mkv(6, 0,0,0,2, 1,1, 0,1,1),
    mkv(6, 1,0,0,2, 1,1, 0,0,1),  // R6 window closed
    mkv(6, 0,0,0,2, 1,1, 1,0,1),
    mkv(7, 1,0,1,2, 1,1, 0,0,1),  // R7 low+miss
    mkv(7, 1,0,0,2, 1,1, 0,0,1),
    mkv(7, 0,0,0,2, 1,1, 1,0,1),  // R7 still fifo
    mkv(10,1,1,1,0, 1,1, 0,0,1),  // R10 limit zero
    mkv(10,1,0,0,0, 1,1, 0,0,1),
    mkv(10,0,0,0,0, 1,1, 1,0,1),
    mkv(11,1,1,1,7, 1,1, 0,0,1),  // R11 limit 7 clamped to 3
    mkv(11,1,0,0,7, 1,1, 0,0,1),
    mkv(11,1,0,0,7, 1,1, 0,0,1),
    mkv(11,1,0,0,7, 1,1, 0,0,1),
    mkv(11,0,0,0,7, 1,1, 0,1,1),  // third redirected block
    mkv(11,1,0,0,7, 1,1, 0,0,1),
    mkv(11,0,0,0,7, 1,1, 1,0,1),  // fourth block back to fifo
    mkv(5, 1,1,1,2, 1,1, 0,0,1),  // R5 reload inside open window
    mkv(5, 1,0,0,2, 1,1, 0,0,1),
    mkv(5, 1,1,1,2, 1,1, 0,0,1),
    mkv(5, 1,0,0,2, 1,1, 0,0,1),
    mkv(5, 1,0,0,2, 1,1, 0,0,1),
    mkv(5, 1,0,0,2, 1,1, 0,0,1),
    mkv(5, 0,0,0,2, 1,1, 1,0,1)   // window was 2 after reload, not 3
  };

  task automatic check3(int req, logic ef, logic ea, logic er, logic [W-1:0] pl);
    n_tests++;
    if ({fifo_valid, assoc_valid, in_ready} !== {ef, ea, er}) begin
      n_fail++;
      $display("FAIL R%0d: {fifo_v,assoc_v,ready} actual %b%b%b expected %b%b%b",
               req, fifo_valid, assoc_valid, in_ready, ef, ea, er);
    end else if (ef && fifo_payload !== pl) begin
      n_fail++;
      $display("FAIL R%0d: fifo_payload actual %0h expected %0h", req, fifo_payload, pl);
    end else if (ea && assoc_payload !== pl) begin
      n_fail++;
      $display("FAIL R%0d: assoc_payload actual %0h expected %0h", req, assoc_payload, pl);
    end
  endtask

  task automatic slot(int req, bit mk, bit hi, bit ms, logic [2:0] c, bit fr, bit ar,
                      bit fl, logic ef, logic ea, logic er, logic [W-1:0] pl);
    @(negedge clk);
    in_valid = 1'b1; in_is_marker = mk; in_tag_high = hi; in_tag_miss = ms;
    cfg = c; fifo_ready = fr; assoc_ready = ar; flush = fl; in_payload = pl;
    #1;
    check3(req, ef, ea, er, pl);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    // R1 reset state: idle outputs
    check3(1, 1'b0, 1'b0, 1'b1, '0);

    for (int i = 0; i < NV; i++) begin
      slot(int'(VEC[i][15:12]), VEC[i][11], VEC[i][10], VEC[i][9], VEC[i][8:6],
           VEC[i][5], VEC[i][4], 1'b0, VEC[i][3], VEC[i][2], VEC[i][1], W'(i + 16));
    end

    // R9 flush mid-window clears counter
    slot(9, 1,1,1,3'd3, 1,1, 0, 0,0,1, 8'hA0);
    slot(9, 0,0,0,3'd3, 1,1, 1, 0,0,0, 8'hA1);  // during flush nothing accepted
    slot(9, 1,0,0,3'd3, 1,1, 0, 0,0,1, 8'hA2);
    slot(9, 0,0,0,3'd3, 1,1, 0, 1,0,1, 8'hA3);  // window gone -> fifo
    // R9 flush returns route to assoc
    slot(9, 0,0,0,3'd3, 1,1, 1, 0,0,0, 8'hA4);
    slot(9, 0,0,0,3'd3, 1,1, 0, 0,1,1, 8'hA5);
    // R2 marker during flush is not taken
    slot(2, 1,0,0,3'd3, 1,1, 1, 0,0,0, 8'hA6);
    slot(2, 0,0,0,3'd3, 1,1, 0, 0,1,1, 8'hA7);  // route still assoc

    // R1 reset mid-run restores defaults
    slot(3, 1,0,0,3'd2, 1,1, 0, 0,0,1, 8'hB0);
    @(negedge clk);
    in_valid = 1'b0; flush = 1'b0; rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    slot(1, 0,0,0,3'd2, 1,1, 0, 0,1,1, 8'hB1);

    @(negedge clk) in_valid = 1'b0;
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule